// File: doc/BRIEF.md
# Posted Store Buffer with Line Snoop

This block sits between a processor's graduation stage and its write path to memory. Every store that graduates is placed in the buffer as an address, a data word and a set of byte enables. This includes stores that hit in the cache. The pipeline can then move on without waiting for the downstream port. Buffered stores leave in arrival order through a valid/ready drain port whenever the downstream side accepts them.

Each held entry stays searchable by address. A snoop port takes a query address and reports at once whether any pending store falls in the same cache line. Lines are 32 bytes, that is 8 words. Hazard logic uses this to stall a conflicting load or refill. The search also covers the store being accepted in that same cycle.

Both ports follow valid/ready rules. The ingress side offers `st_ready` only while a free slot exists. The ready depends on occupancy alone, not on `dr_ready`, so a full buffer refuses a store even in a cycle where it drains. On the drain side the head entry is presented while `dr_valid` is high and stays unchanged until `dr_ready` is seen with it.

Top module: `store_post_buf`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `dr_valid` is 0, `st_ready` is 1 and `snp_hit` is 0.
- R2: A store is taken on a clock edge where `st_valid` and `st_ready` are both 1. `st_ready` is 1 exactly when fewer than DEPTH (8) entries are held.
- R3: Entries leave in the order they were taken. While any entry is held, `dr_valid` is 1 and `dr_addr`, `dr_data` and `dr_be` carry the oldest entry.
- R4: The head entry is released only on an edge with `dr_valid` and `dr_ready` both 1. Otherwise the drain outputs hold their values.
- R5: A store taken and an entry released on the same edge leave the occupancy unchanged.
- R6: After DEPTH stores with no release, `full` is 1. A store offered while full has no effect: it is never drained and never matches a snoop.
- R7: `snp_hit` is 1 in the same cycle when any held entry has address bits [31:5] equal to `snp_addr[31:5]`. Bits [4:0] play no part in the comparison.
- R8: A store being taken in the current cycle counts for `snp_hit` in that same cycle.
- R9: An entry that has been released no longer contributes to `snp_hit`.
- R10: `empty` is 1 exactly when no entry is held, and then `dr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| st_valid | input | 1 | Graduated store is offered |
| st_ready | output | 1 | A slot is free for a store |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data word |
| st_be | input | 4 | Store byte enables |
| dr_valid | output | 1 | Head entry is presented downstream |
| dr_ready | input | 1 | Downstream accepts the head entry |
| dr_addr | output | 32 | Head entry address |
| dr_data | output | 32 | Head entry data |
| dr_be | output | 4 | Head entry byte enables |
| snp_addr | input | 32 | Snoop query address |
| snp_hit | output | 1 | A pending store shares the queried line |
| full | output | 1 | All slots are occupied |
| empty | output | 1 | No slot is occupied |

## Verification
The hardest condition to reach is a store arriving and an entry draining on the same edge while the pointers sit at non-trivial positions. That edge has to leave the occupancy exactly where it was. The stimulus first loads seven entries with the drain held off. It then offers a store together with `dr_ready` and checks that exactly one more store is then needed to raise `full`. A store offered while the buffer is full is followed by a snoop of its address and a look at the head, which shows it left no trace. Each drained line is snooped right after its release, so a stale slot still matching would be caught.

// File: rtl/spb_pkg.sv
package spb_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
  } spb_entry_t;
endpackage

// File: rtl/spb_ctrl.sv
module spb_ctrl #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [DEPTH-1:0] live,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    always_ff @(posedge clk) begin
      if (!rst_n)                            live[i] <= 1'b0;
      else if (push && wr_ptr == PTR_W'(i))  live[i] <= 1'b1;
      else if (pop && rd_ptr == PTR_W'(i))   live[i] <= 1'b0;
    end
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5
  same_edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> count == $past(count));

  // R2
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count == $past(count) + 1'b1);

  // R10
  live_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(live) == 32'(count));
endmodule

// File: rtl/spb_store.sv
module spb_store
  import spb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_ptr,
  input  spb_entry_t             wr_ent,
  input  logic [PTR_W-1:0]       rd_ptr,
  output spb_entry_t             rd_ent,
  output spb_entry_t [DEPTH-1:0] ents
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_ptr == PTR_W'(i)) ents[i] <= wr_ent;
    end
  end

  assign rd_ent = ents[rd_ptr];
endmodule

// File: rtl/spb_snoop.sv
module spb_snoop
  import spb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OFS_W = 5
) (
  input  spb_entry_t [DEPTH-1:0] ents,
  input  logic [DEPTH-1:0]       live,
  input  logic [ADDR_W-1:0]      snp_addr,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic                   in_take,
  output logic                   hit
);
  localparam int TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0] q_tag;
  logic [DEPTH-1:0] match;
  logic             in_match;

  assign q_tag = snp_addr[ADDR_W-1:OFS_W];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = live[i] && (ents[i].addr[ADDR_W-1:OFS_W] == q_tag);
  end

  assign in_match = in_take && (in_addr[ADDR_W-1:OFS_W] == q_tag);
  assign hit      = (|match) || in_match;
endmodule

// File: rtl/store_post_buf.sv
module store_post_buf
  import spb_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              dr_valid,
  input  logic              dr_ready,
  output logic [ADDR_W-1:0] dr_addr,
  output logic [DATA_W-1:0] dr_data,
  output logic [BE_W-1:0]   dr_be,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OFS_W = $clog2(LINE_BYTES);

  logic                   push, pop;
  logic [PTR_W-1:0]       wr_ptr, rd_ptr;
  logic [DEPTH-1:0]       live;
  spb_entry_t             in_ent, head;
  spb_entry_t [DEPTH-1:0] ents;

  assign st_ready = !full;
  assign push     = st_valid && !full;
  assign dr_valid = !empty;
  assign pop      = dr_valid && dr_ready;
  assign in_ent   = '{addr: st_addr, data: st_data, be: st_be};

  spb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .live(live),
    .full(full), .empty(empty)
  );

  spb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(push), .wr_ptr(wr_ptr), .wr_ent(in_ent),
    .rd_ptr(rd_ptr), .rd_ent(head), .ents(ents)
  );

  spb_snoop #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_snoop (
    .ents(ents), .live(live), .snp_addr(snp_addr),
    .in_addr(st_addr), .in_take(push), .hit(snp_hit)
  );

  assign dr_addr = head.addr;
  assign dr_data = head.data;
  assign dr_be   = head.be;

  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_ready) |=> dr_valid && $stable(dr_addr)
                                && $stable(dr_data) && $stable(dr_be));

  // R7
  idle_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |-> !snp_hit);

  // R8
  fresh_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && st_addr[ADDR_W-1:OFS_W] == snp_addr[ADDR_W-1:OFS_W]) |-> snp_hit);

  // R6
  full_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: tb/store_post_buf_tb.sv
`timescale 1ns/1ps
module store_post_buf_tb;
  localparam int DEPTH = 8;
  localparam int NV    = 8;
  localparam logic [67:0] VEC [NV] = '{
    {32'h0000_1000, 32'h1111_0000, 4'hf},
    {32'h0000_1024, 32'h2222_0001, 4'h1},
    {32'h8000_0040, 32'h3333_0002, 4'h3},
    {32'h8000_0088, 32'h4444_0003, 4'hc},
    {32'h1234_5600, 32'h5555_0004, 4'h1},
    {32'h1234_5660, 32'h6666_0005, 4'h8},
    {32'hFFFF_FFE0, 32'h7777_0006, 4'hf},
    {32'h0ABC_DE14, 32'h8888_0007, 4'h6}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, dr_ready = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0, snp_addr = '0;
  logic [3:0]  st_be = '0;
  logic st_ready, dr_valid, snp_hit, full, empty;
  logic [31:0] dr_addr, dr_data;
  logic [3:0]  dr_be;

  int n_chk = 0, n_fail = 0;
  logic [67:0] q[$];

  always #2.5 clk = ~clk;

  store_post_buf #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_data(dr_data), .dr_be(dr_be), .snp_addr(snp_addr),
    .snp_hit(snp_hit), .full(full), .empty(empty)
  );

  task automatic chk(input string req, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [67:0] e, input bit rdy, input logic [31:0] sa);
    st_valid = v;
    {st_addr, st_data, st_be} = e;
    dr_ready = rdy;
    snp_addr = sa;
    #1;
  endtask

  task automatic step();
    bit p, d;
    logic [67:0] e;
    p = st_valid && (q.size() < DEPTH);
    d = dr_ready && (q.size() != 0);
    e = {st_addr, st_data, st_be};
    @(posedge clk);
    @(negedge clk);
    if (d) void'(q.pop_front());
    if (p) q.push_back(e);
  endtask

  task automatic chk_head(input string req);
    if (q.size() == 0) chk(req, 68'(dr_valid), 68'd0);
    else begin
      chk(req, 68'(dr_valid), 68'd1);
      chk(req, {dr_addr, dr_data, dr_be}, q[0]);
    end
  endtask

  initial begin
    #(5 * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 empty", 68'(empty), 68'd1);
    chk("R1 full", 68'(full), 68'd0);
    chk("R1 dr_valid", 68'(dr_valid), 68'd0);
    chk("R1 st_ready", 68'(st_ready), 68'd1);
    chk("R1 snp_hit", 68'(snp_hit), 68'd0);

    // Walk the vector table: fill with drain held off
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i], 1'b0, VEC[i][67:36]);
      chk("R2 st_ready", 68'(st_ready), 68'd1);
      chk("R8 same-cycle snoop", 68'(snp_hit), 68'd1);
      step();
    end
    drive(1'b0, '0, 1'b0, 32'h7000_0000);
    chk("R6 full", 68'(full), 68'd1);
    chk("R10 not empty", 68'(empty), 68'd0);
    chk("R7 miss", 68'(snp_hit), 68'd0);
    drive(1'b0, '0, 1'b0, 32'h8000_009C);
    chk("R7 offset ignored", 68'(snp_hit), 68'd1);

    // Store offered while full is dropped
    drive(1'b1, {32'h6000_0004, 32'hDEAD_BEEF, 4'hf}, 1'b0, 32'h7000_0000);
    chk("R6 st_ready low", 68'(st_ready), 68'd0);
    step();
    drive(1'b0, '0, 1'b0, 32'h6000_0004);
    chk("R6 dropped store unseen", 68'(snp_hit), 68'd0);
    chk_head("R4 head held");
    step();
    chk_head("R4 head held again");

    // Drain in order, snooping released lines
    for (int i = 0; i < NV; i++) begin
      drive(1'b0, '0, 1'b1, VEC[i][67:36]);
      chk("R3 order", {dr_addr, dr_data, dr_be}, VEC[i]);
      chk("R7 held line hit", 68'(snp_hit), 68'd1);
      step();
      drive(1'b0, '0, 1'b0, VEC[i][67:36]);
      chk("R9 released line miss", 68'(snp_hit), 68'd0);
    end
    chk("R10 empty", 68'(empty), 68'd1);
    chk("R10 dr_valid low", 68'(dr_valid), 68'd0);

    // Same-edge take and release
    for (int i = 0; i < 7; i++) begin
      drive(1'b1, VEC[i], 1'b0, 32'h0);
      step();
    end
    drive(1'b1, VEC[7], 1'b1, 32'h0);
    step();
    drive(1'b0, '0, 1'b0, 32'h0);
    chk("R5 count kept", 68'(full), 68'd0);
    drive(1'b1, {32'h0000_2000, 32'h9999_0009, 4'h5}, 1'b0, 32'h0);
    step();
    drive(1'b0, '0, 1'b0, 32'h0);
    chk("R5 one more fills", 68'(full), 68'd1);

    while (q.size() != 0) begin
      drive(1'b0, '0, 1'b1, 32'h0);
      chk_head("R3 drain order");
      step();
    end
    drive(1'b0, '0, 1'b0, 32'h0);
    chk("R10 empty at end", 68'(empty), 68'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule